// File: doc/BRIEF.md
# Reference Lock Decision Controller

This controller decides whether a clock recovery loop should follow the incoming serial data or fall back to the local reference clock. It counts edges of a recovered word-rate clock over a fixed window of reference clock cycles. The signed difference from the nominal count is turned into an absolute error. A two-state machine with asymmetric hysteresis uses that error to update its lock state once per window.

Staying locked tolerates twice the error that acquiring lock does. Each state also has an intermediate band where the current state is kept. A loss-of-signal flag from an upstream run-length checker forces the select to the reference clock while it is high. That flag does not alter the frequency lock state. The analog loop and the clock switching are outside this block.

States: `ST_UNLOCKED` (reset state, reference tracking) and `ST_LOCKED`.

Transitions, evaluated only on a completed window:
- `ACQUIRE`: `ST_UNLOCKED` to `ST_LOCKED`.
- `DROP`: `ST_LOCKED` to `ST_UNLOCKED`.
- `HOLD`: the state is kept.

Top module: `ref_lock_ctrl`

## Requirements
- R1: After reset the state is `ST_UNLOCKED`, and both `locked` and `track_data` are 0.
- R2: The error is measured once every 2^WIN_LOG2 reference cycles. The first window after reset only captures a starting count and makes no decision.
- R3: The error is the absolute difference between the word-clock edges counted in a window and 2^WIN_LOG2.
- R4: In `ST_UNLOCKED`, an error strictly below ACQ_LO (default 4 counts) takes `ACQUIRE`.
- R5: In `ST_UNLOCKED`, an error from ACQ_LO to ACQ_HI inclusive (default 4..6) takes `HOLD`. An error above ACQ_HI also leaves the state unlocked.
- R6: In `ST_LOCKED`, an error strictly below KEEP_LO (default 8) keeps the state locked.
- R7: In `ST_LOCKED`, an error from KEEP_LO to KEEP_HI inclusive (default 8..12) takes `HOLD`. An error above KEEP_HI takes `DROP`.
- R8: While `los` is 1, `track_data` is 0 from the next reference edge onward. `los` has no effect on `locked`.
- R9: `track_data` is 1 only when the controller is in `ST_LOCKED` and `los` was 0 at the previous reference edge.
- R10: The lock state changes only on the reference edge that completes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; all decisions run on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_clk | input | 1 | Recovered word-rate clock, nominally equal to ref_clk |
| los | input | 1 | Loss of signal from the run-length checker, synchronous to ref_clk |
| track_data | output | 1 | 1 = follow incoming data, 0 = follow reference |
| locked | output | 1 | 1 while the state is `ST_LOCKED` |

## Verification
The assertions assume that `los` is synchronous to `ref_clk`. They also assume `word_clk` stays close enough to nominal that a window never counts more than twice the nominal number of edges, since the count difference wraps beyond that. The stimulus keeps within this by changing `los` only away from reference edges. It also drives `word_clk` with offsets of at most 20 counts per window. Because clock phase makes the measured count uncertain by one, whole-system offsets are placed in the middle of each band. The exact band edges are swept directly on the classifier.

// File: rtl/rld_pkg.sv
package rld_pkg;

    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        BAND_PASS = 2'd0,
        BAND_HOLD = 2'd1,
        BAND_FAIL = 2'd2
    } err_band_e;

endpackage

// File: rtl/rld_word_counter.sv
// Free-running Gray-coded edge counter in the recovered word clock domain.
module rld_word_counter #(
    parameter int CW = 16
) (
    input  logic          word_clk,
    input  logic          rst_n,
    output logic [CW-1:0] gray_o
);
    logic          rst_s1, rst_s2;
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_d;

    always_ff @(posedge word_clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_s1 <= 1'b0;
            rst_s2 <= 1'b0;
        end else begin
            rst_s1 <= 1'b1;
            rst_s2 <= rst_s1;
        end
    end

    assign bin_d = bin_q + CW'(1);

    always_ff @(posedge word_clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else if (rst_s2) begin
            bin_q  <= bin_d;
            gray_o <= bin_d ^ (bin_d >> 1);
        end
    end
endmodule

// File: rtl/rld_window_meter.sv
// Synchronises the Gray count, closes a window every 2^WIN_LOG2 reference
// cycles and reports the absolute deviation from the nominal count.
module rld_window_meter #(
    parameter int WIN_LOG2 = 14,
    parameter int CW       = WIN_LOG2 + 2
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic [CW-1:0] word_gray,
    output logic          meas_valid,
    output logic          win_end,
    output logic [CW-1:0] abs_err
);
    localparam logic [CW-1:0] NOMINAL = CW'(1) << WIN_LOG2;

    logic [WIN_LOG2-1:0] win_cnt;
    logic [CW-1:0]       g_s1, g_s2;
    logic [CW-1:0]       bin_now;
    logic [CW-1:0]       snap_q;
    logic [CW-1:0]       delta;
    logic [CW-1:0]       diff;
    logic [CW-1:0]       mag;
    logic                primed_q;

    assign win_end = &win_cnt;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
            g_s1    <= '0;
            g_s2    <= '0;
        end else begin
            win_cnt <= win_cnt + WIN_LOG2'(1);
            g_s1    <= word_gray;
            g_s2    <= g_s1;
        end
    end

    always_comb begin
        bin_now[CW-1] = g_s2[CW-1];
        for (int i = CW - 2; i >= 0; i--) begin
            bin_now[i] = bin_now[i+1] ^ g_s2[i];
        end
    end

    assign delta = bin_now - snap_q;
    assign diff  = delta - NOMINAL;
    assign mag   = diff[CW-1] ? (~diff + CW'(1)) : diff;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q     <= '0;
            primed_q   <= 1'b0;
            meas_valid <= 1'b0;
            abs_err    <= '0;
        end else begin
            meas_valid <= win_end && primed_q;
            if (win_end) begin
                snap_q   <= bin_now;
                primed_q <= 1'b1;
                abs_err  <= mag;
            end
        end
    end

    // R2: a result never appears on two consecutive edges
    assert_single_pulse_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    // R2: a result only follows a window closing edge
    assert_valid_after_window_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        meas_valid |-> $past(win_end));
endmodule

// File: rtl/rld_band_classifier.sv
// Maps the absolute error to pass / hold / fail using thresholds chosen by
// the current lock state; both boundary values fall into the hold band.
module rld_band_classifier
    import rld_pkg::*;
#(
    parameter int CW      = 16,
    parameter int ACQ_LO  = 4,
    parameter int ACQ_HI  = 6,
    parameter int KEEP_LO = 8,
    parameter int KEEP_HI = 12
) (
    input  lock_state_e   state,
    input  logic [CW-1:0] err,
    output err_band_e     band
);
    logic [CW-1:0] lo_thr, hi_thr;

    always_comb begin
        unique case (state)
            ST_UNLOCKED: begin
                lo_thr = CW'(ACQ_LO);
                hi_thr = CW'(ACQ_HI);
            end
            ST_LOCKED: begin
                lo_thr = CW'(KEEP_LO);
                hi_thr = CW'(KEEP_HI);
            end
            default: begin
                lo_thr = CW'(ACQ_LO);
                hi_thr = CW'(ACQ_HI);
            end
        endcase
        if (err < lo_thr)       band = BAND_PASS;
        else if (err > hi_thr)  band = BAND_FAIL;
        else                    band = BAND_HOLD;
    end
endmodule

// File: rtl/ref_lock_ctrl.sv
module ref_lock_ctrl
    import rld_pkg::*;
#(
    parameter int WIN_LOG2 = 14,
    parameter int ACQ_LO   = 4,
    parameter int ACQ_HI   = 6,
    parameter int KEEP_LO  = 8,
    parameter int KEEP_HI  = 12
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic word_clk,
    input  logic los,
    output logic track_data,
    output logic locked
);
    localparam int CW = WIN_LOG2 + 2;

    logic [CW-1:0] word_gray;
    logic          meas_valid;
    logic          win_end;
    logic [CW-1:0] abs_err;
    err_band_e     band;
    lock_state_e   state_q, state_d;

    rld_word_counter #(.CW(CW)) i_word_counter (
        .word_clk (word_clk),
        .rst_n    (rst_n),
        .gray_o   (word_gray)
    );

    rld_window_meter #(.WIN_LOG2(WIN_LOG2), .CW(CW)) i_window_meter (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .word_gray  (word_gray),
        .meas_valid (meas_valid),
        .win_end    (win_end),
        .abs_err    (abs_err)
    );

    rld_band_classifier #(
        .CW(CW), .ACQ_LO(ACQ_LO), .ACQ_HI(ACQ_HI),
        .KEEP_LO(KEEP_LO), .KEEP_HI(KEEP_HI)
    ) i_classifier (
        .state (state_q),
        .err   (abs_err),
        .band  (band)
    );

    // Next-state decision: ACQUIRE, DROP or HOLD
    always_comb begin
        state_d = state_q;
        if (meas_valid) begin
            unique case (state_q)
                ST_UNLOCKED: if (band == BAND_PASS) state_d = ST_LOCKED;
                ST_LOCKED:   if (band == BAND_FAIL) state_d = ST_UNLOCKED;
                default:     state_d = ST_UNLOCKED;
            endcase
        end
    end

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNLOCKED;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) track_data <= 1'b0;
        else        track_data <= (state_d == ST_LOCKED) && !los;
    end

    assign locked = (state_q == ST_LOCKED);

    // R10: state moves only after a completed measurement
    assert_state_on_window_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(meas_valid));

    // R9: data tracking requires the locked state
    assert_track_needs_lock_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        track_data |-> locked);

    // R8: loss of signal forces reference tracking on the next edge
    assert_los_forces_ref_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        los |=> !track_data);

    // R5: a large error never acquires lock
    assert_no_acquire_high_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_valid && !locked && abs_err >= CW'(ACQ_LO)) |=> !locked);

    // R6: a small error never drops lock
    assert_keep_small_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_valid && locked && abs_err < CW'(KEEP_LO)) |=> locked);

    // R7: a large error always drops lock
    assert_drop_large_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_valid && locked && abs_err > CW'(KEEP_HI)) |=> !locked);
endmodule

// File: tb/test_ref_lock_ctrl.sv
`timescale 1ns/1ps
module test_ref_lock_ctrl;
    import rld_pkg::*;

    localparam realtime CLK_PERIOD = 10.0;
    localparam int WIN_LOG2 = 10;
    localparam int WIN      = 1 << WIN_LOG2;
    localparam int CW       = WIN_LOG2 + 2;
    localparam int ACQ_LO = 4, ACQ_HI = 6, KEEP_LO = 8, KEEP_HI = 12;

    logic ref_clk = 1'b0;
    logic word_clk = 1'b0;
    logic rst_n = 1'b0;
    logic los = 1'b0;
    logic track_data, locked;
    realtime word_half = CLK_PERIOD / 2.0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    ref_lock_ctrl #(
        .WIN_LOG2(WIN_LOG2), .ACQ_LO(ACQ_LO), .ACQ_HI(ACQ_HI),
        .KEEP_LO(KEEP_LO), .KEEP_HI(KEEP_HI)
    ) i_ref_lock_ctrl (
        .ref_clk(ref_clk), .rst_n(rst_n), .word_clk(word_clk),
        .los(los), .track_data(track_data), .locked(locked)
    );

    // Stand-alone classifier for the exhaustive band-edge sweep
    lock_state_e   sw_state = ST_UNLOCKED;
    logic [CW-1:0] sw_err = '0;
    err_band_e     sw_band;

    rld_band_classifier #(
        .CW(CW), .ACQ_LO(ACQ_LO), .ACQ_HI(ACQ_HI),
        .KEEP_LO(KEEP_LO), .KEEP_HI(KEEP_HI)
    ) i_sweep (.state(sw_state), .err(sw_err), .band(sw_band));

    always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;
    always #(word_half) word_clk = ~word_clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // word clock with d extra edges per window
    task automatic set_offset(input int d);
        word_half = (CLK_PERIOD * WIN) / (2.0 * (WIN + d));
    endtask

    task automatic run_windows(input int n);
        repeat (n * WIN) @(negedge ref_clk);
    endtask

    task automatic step(input int d, input string req, input int exp_lock);
        set_offset(d);
        run_windows(3);
        check(req, int'(locked), exp_lock);
        check(req, int'(track_data), exp_lock);
    endtask

    initial begin
        // Band-edge sweep, expected bands computed arithmetically
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e <= 20; e++) begin
                int lo, hi, exp_b;
                sw_state = (s == 0) ? ST_UNLOCKED : ST_LOCKED;
                sw_err   = CW'(e);
                lo = (s == 0) ? ACQ_LO : KEEP_LO;
                hi = (s == 0) ? ACQ_HI : KEEP_HI;
                exp_b = (e < lo) ? 0 : ((e > hi) ? 2 : 1);
                #1;
                if (s == 0) check((e < lo) ? "R4" : "R5", int'(sw_band), exp_b);
                else        check((e < lo) ? "R6" : "R7", int'(sw_band), exp_b);
            end
        end

        // R1: reset state
        repeat (3) @(negedge ref_clk);
        check("R1", int'(locked), 0);
        check("R1", int'(track_data), 0);
        rst_n = 1'b1;

        // R2: exact nominal rate, but the first window only primes
        set_offset(0);
        repeat (WIN - 4) @(negedge ref_clk);
        check("R2", int'(locked), 0);

        // R5: far off stays unlocked, mid hold band stays unlocked
        step(20, "R5", 0);
        step(5,  "R5", 0);
        // R3 R4: small error acquires lock
        step(2,  "R4", 1);
        // R7: hold band in locked state keeps lock, both signs (R3)
        step(10,  "R7", 1);
        step(-10, "R3", 1);
        step(-2,  "R6", 1);

        // R8 R9: loss of signal forces reference, lock unaffected
        @(negedge ref_clk);
        los = 1'b1;
        @(negedge ref_clk);
        check("R8", int'(track_data), 0);
        repeat (50) @(negedge ref_clk);
        check("R8", int'(locked), 1);
        check("R8", int'(track_data), 0);
        los = 1'b0;
        @(negedge ref_clk);
        check("R9", int'(track_data), 1);

        // R7: large error drops lock; R10 lock held until window completes
        step(20, "R7", 0);
        step(-2, "R4", 1);
        set_offset(-20);
        repeat (WIN / 2) @(negedge ref_clk);
        check("R10", int'(locked), 1);
        run_windows(3);
        check("R7", int'(locked), 0);
        check("R9", int'(track_data), 0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge ref_clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule